// File: doc/BRIEF.md
# Dual-Rate Clock Phase Indicator

This block drives a single bit that tells logic clocked by a doubled clock which half of the slower base clock period is in progress. It receives a base (1x) clock and a phase-aligned fast (2x) clock, whose rising edges coincide with every base rising edge. It also receives an optional lock-status input. Fast-domain logic uses the output, sampled on the fast clock, to tell the two fast cycles inside one base cycle apart. Examples are a port shared between two fast-clock accesses, or a two-beat datapath running under a slow control domain.

A parameter chooses one of two structures when the design is elaborated. The cross-clear structure uses a base-clocked register that is set on every base edge. A fast-clocked register clears it again through an asynchronous path. Its pulse therefore always starts on a base rising edge, and it puts itself back in step after a clock disturbance. The chain structure passes a start condition through a fast flop and then a base flop, and uses it to enable a fast-clocked toggle flop. The toggle stays quiet until both clocks have produced edges. Both structures avoid the failure of a bare toggle on the fast clock, whose output can settle in the wrong polarity with respect to the base clock.

Top module: `dual_rate_phase`

## Requirements
- R1: While `rst_ni` is low, `phase_o` is low. Asserting `rst_ni` low forces `phase_o` low at once, without waiting for any clock edge.
- R2: With `ARCH = DRP_XCLR` and both clocks running with lock high, `phase_o` rises on each base rising edge and falls on the next fast rising edge. It is high for the first half of every base period and low for the second half.
- R3: With `ARCH = DRP_XCLR`, `phase_o` stays low while only the fast clock runs. When the base clock then starts, the pattern of R2 holds from the first base period.
- R4: With `ARCH = DRP_CHAIN` and both clocks running with lock high, `phase_o` is low for the first half of every base period. It is high from the mid-period fast rising edge until the next base rising edge.
- R5: With `ARCH = DRP_CHAIN`, `phase_o` stays low while only one of the two clocks runs. The pattern of R4 appears no later than the second base period after both clocks run.
- R6: After `rst_ni` is released inside a base period with both clocks running, either structure shows its full pattern (R2 or R4) from the next base period onward.
- R7: With `USE_LOCK = 1`, `phase_o` is low in every base period that starts after `lock_i` has been seen low. When `lock_i` goes high again during a base period, the full pattern with its normal polarity returns from the base period after the next one at the latest.
- R8: `phase_o` is never high at two consecutive fast rising edges. Each pulse lasts at most one fast period.
- R9: With `USE_LOCK = 0`, `lock_i` has no effect, and the indicator runs as though lock were always high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_base_i | input | 1 | Base (1x) clock |
| clk_fast_i | input | 1 | Fast (2x) clock, rising edges aligned with base rising edges |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lock_i | input | 1 | Clock-lock status. Low stops the indicator when `USE_LOCK = 1` |
| phase_o | output | 1 | Half-period phase indicator |

## Verification
The bench builds three copies of the block that share the same clocks:
- cross-clear with lock honoured;
- chain with lock honoured;
- chain with `USE_LOCK = 0` and its lock input tied low.

Each copy has its own lock line. This lets the lock-loss and lock-return sequence of R7 run on the first two copies while the third keeps running to show R9. It also lets the cross-clear copy be held quiet while only the base clock runs. The clock generator can stop either clock and restart it on an aligned edge, which makes the start-order cases of R3 and R5 reachable.

// File: rtl/drp_pkg.sv
`timescale 1ns/1ps
package drp_pkg;

   // Structure used to build the phase indicator.
   typedef enum logic {
      DRP_XCLR  = 1'b0,   // two registers that clear each other
      DRP_CHAIN = 1'b1    // fast flop -> base flop -> fast toggle
   } drp_arch_e;

endpackage

// File: rtl/drp_xclr_core.sv
`timescale 1ns/1ps
// Cross-clearing pair: the set flop is clocked by the base clock; the fast
// flop clears it again one fast period later.
module drp_xclr_core (
   input  logic clk_base_i,
   input  logic clk_fast_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic phase_o
);

   logic set_q;     // base-clocked, drives the indicator
   logic kill_q;    // fast-clocked, requests the clear
   logic set_clr_n;

   // The set flop is cleared by reset or by the fast flop.
   assign set_clr_n = rst_ni & ~kill_q;

   always_ff @(posedge clk_base_i or negedge set_clr_n) begin
      if (!set_clr_n) begin
         set_q <= 1'b0;
      end else begin
         set_q <= start_i;
      end
   end

   // A low indicator holds the fast flop cleared, which frees the set flop.
   always_ff @(posedge clk_fast_i or negedge set_q) begin
      if (!set_q) begin
         kill_q <= 1'b0;
      end else begin
         kill_q <= set_q;
      end
   end

   assign phase_o = set_q;

endmodule

// File: rtl/drp_chain_core.sv
`timescale 1ns/1ps
// Start chain: a fast flop feeds a base flop, whose output enables a toggle
// flop clocked by the fast clock.
module drp_chain_core (
   input  logic clk_base_i,
   input  logic clk_fast_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic phase_o
);

   logic fast_seen_q;   // proves the fast clock ticks
   logic base_seen_q;   // proves the base clock ticks
   logic tog_q;

   always_ff @(posedge clk_fast_i or negedge rst_ni) begin
      if (!rst_ni) begin
         fast_seen_q <= 1'b0;
      end else begin
         fast_seen_q <= start_i;
      end
   end

   always_ff @(posedge clk_base_i or negedge rst_ni) begin
      if (!rst_ni) begin
         base_seen_q <= 1'b0;
      end else begin
         base_seen_q <= fast_seen_q;
      end
   end

   always_ff @(posedge clk_fast_i or negedge rst_ni) begin
      if (!rst_ni) begin
         tog_q <= 1'b0;
      end else if (base_seen_q) begin
         tog_q <= ~tog_q;
      end
   end

   assign phase_o = tog_q;

endmodule

// File: rtl/dual_rate_phase.sv
`timescale 1ns/1ps
module dual_rate_phase #(
   parameter drp_pkg::drp_arch_e ARCH     = drp_pkg::DRP_XCLR,
   parameter bit                 USE_LOCK = 1'b1
) (
   input  logic clk_base_i,
   input  logic clk_fast_i,
   input  logic rst_ni,
   input  logic lock_i,
   output logic phase_o
);

   logic start;

   // Start condition: the lock status, or a constant high when lock is unused.
   if (USE_LOCK) begin : g_lock
      assign start = lock_i;
   end else begin : g_nolock
      assign start = 1'b1;
   end

   if (ARCH == drp_pkg::DRP_XCLR) begin : g_xclr
      drp_xclr_core u_core (
         .clk_base_i (clk_base_i),
         .clk_fast_i (clk_fast_i),
         .rst_ni     (rst_ni),
         .start_i    (start),
         .phase_o    (phase_o)
      );
   end else if (ARCH == drp_pkg::DRP_CHAIN) begin : g_chain
      drp_chain_core u_core (
         .clk_base_i (clk_base_i),
         .clk_fast_i (clk_fast_i),
         .rst_ni     (rst_ni),
         .start_i    (start),
         .phase_o    (phase_o)
      );
   end else begin : g_bad_arch
      $error("dual_rate_phase: unsupported ARCH value");
   end

endmodule

// File: rtl/dual_rate_phase_chk.sv
`timescale 1ns/1ps
module dual_rate_phase_chk #(
   parameter drp_pkg::drp_arch_e ARCH     = drp_pkg::DRP_XCLR,
   parameter bit                 USE_LOCK = 1'b1
) (
   input logic clk_base_i,
   input logic clk_fast_i,
   input logic rst_ni,
   input logic lock_i,
   input logic phase_o
);

   // R1: a reset seen at a fast edge leaves the indicator low
   p_reset_low_r1: assert property (@(posedge clk_fast_i)
      !rst_ni |-> !phase_o)
      else $error("R1: indicator high during reset");

   // R8: never high at two fast edges in a row
   p_single_pulse_r8: assert property (@(posedge clk_fast_i) disable iff (!rst_ni)
      phase_o |=> !phase_o)
      else $error("R8: indicator high for more than one fast period");

   if (ARCH == drp_pkg::DRP_XCLR) begin : g_xclr_chk
      // R2: just before each base rising edge the indicator is low
      p_low_before_base_edge_r2: assert property (@(posedge clk_base_i) disable iff (!rst_ni)
         !phase_o)
         else $error("R2: indicator high across a base rising edge");
   end

   if (USE_LOCK) begin : g_lock_chk
      // R7: three base edges with lock low leave the indicator low
      p_lock_low_quiet_r7: assert property (@(posedge clk_base_i) disable iff (!rst_ni)
         (!lock_i && !$past(lock_i) && !$past(lock_i, 2)) |-> !phase_o)
         else $error("R7: indicator active while lock is low");
   end

endmodule

bind dual_rate_phase dual_rate_phase_chk #(
   .ARCH     (ARCH),
   .USE_LOCK (USE_LOCK)
) u_chk (
   .clk_base_i (clk_base_i),
   .clk_fast_i (clk_fast_i),
   .rst_ni     (rst_ni),
   .lock_i     (lock_i),
   .phase_o    (phase_o)
);

// File: tb/dual_rate_phase_tb.sv
`timescale 1ns/1ps
module dual_rate_phase_tb;

   logic clk_1x, clk_2x;
   logic rst_n;
   logic lock_a, lock_b;
   logic ph_x, ph_c, ph_n;

   logic [1:0] tick;
   bit run1 = 1'b1;
   bit run2 = 1'b1;
   bit en1  = 1'b1;
   bit done = 1'b0;
   int vectors = 0;
   int miscompares = 0;

   // 50 MHz fast clock, 25 MHz base clock. The base clock can only be
   // switched at a tick where both clocks are low or rising together.
   initial begin
      tick   = 2'd0;
      clk_2x = 1'b0;
      clk_1x = 1'b0;
      forever begin
         #10;
         tick = tick + 2'd1;
         if (tick == 2'd0) en1 = run1;
         clk_2x = ~tick[0] & run2;
         clk_1x = tick[1] & en1;
      end
   end

   dual_rate_phase #(.ARCH(drp_pkg::DRP_XCLR), .USE_LOCK(1'b1)) u_dut (
      .clk_base_i(clk_1x), .clk_fast_i(clk_2x), .rst_ni(rst_n),
      .lock_i(lock_a), .phase_o(ph_x));

   dual_rate_phase #(.ARCH(drp_pkg::DRP_CHAIN), .USE_LOCK(1'b1)) u_dut_chain (
      .clk_base_i(clk_1x), .clk_fast_i(clk_2x), .rst_ni(rst_n),
      .lock_i(lock_b), .phase_o(ph_c));

   dual_rate_phase #(.ARCH(drp_pkg::DRP_CHAIN), .USE_LOCK(1'b0)) u_dut_nolock (
      .clk_base_i(clk_1x), .clk_fast_i(clk_2x), .rst_ni(rst_n),
      .lock_i(1'b0), .phase_o(ph_n));

   task automatic chk(input logic act, input logic exp, input string tag);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // One base period from its rising edge: samples in the first and second half.
   task automatic chk_period(input bit xo, input bit co, input bit no,
                             input string tx, input string tc, input string tn);
      @(posedge clk_1x);
      #5;  chk(ph_x, xo, tx); chk(ph_c, 1'b0, tc); chk(ph_n, 1'b0, tn);
      #10; chk(ph_x, xo, tx); chk(ph_c, 1'b0, tc); chk(ph_n, 1'b0, tn);
      #10; chk(ph_x, 1'b0, tx); chk(ph_c, co, tc); chk(ph_n, no, tn);
      #10; chk(ph_x, 1'b0, tx); chk(ph_c, co, tc); chk(ph_n, no, tn);
   endtask

   task automatic release_reset();
      @(posedge clk_1x);
      #5 rst_n = 1'b1;
   endtask

   // R1, R6: quiet under reset, full pattern from the first period after release
   task automatic t_reset_and_start();
      repeat (6) begin
         #7;
         chk(ph_x, 1'b0, "R1 xclr"); chk(ph_c, 1'b0, "R1 chain"); chk(ph_n, 1'b0, "R1 nolock");
      end
      release_reset();
      repeat (3) chk_period(1'b1, 1'b1, 1'b1, "R6 R2 R8 xclr", "R6 R4 R8 chain", "R6 R9 nolock");
   endtask

   // R1: reset asserted mid-pulse clears the output immediately
   task automatic t_async_reset();
      @(posedge clk_1x);
      #5 rst_n = 1'b0;
      #1 chk(ph_x, 1'b0, "R1 async xclr");
      release_reset();
      chk_period(1'b1, 1'b1, 1'b1, "R6 xclr", "R6 chain", "R6 nolock");
      @(posedge clk_1x);
      #25 rst_n = 1'b0;
      #1 chk(ph_c, 1'b0, "R1 async chain"); chk(ph_n, 1'b0, "R1 async nolock");
      release_reset();
      repeat (2) chk_period(1'b1, 1'b1, 1'b1, "R6 xclr", "R6 chain", "R6 nolock");
   endtask

   // R7, R9: lock loss stops the first two copies, the third keeps going
   task automatic t_lock_loss();
      @(posedge clk_1x);
      #5 begin lock_a = 1'b0; lock_b = 1'b0; end
      repeat (3) chk_period(1'b0, 1'b0, 1'b1, "R7 xclr", "R7 chain", "R9 nolock");
      @(posedge clk_1x);
      #5 begin lock_a = 1'b1; lock_b = 1'b1; end
      repeat (3) chk_period(1'b1, 1'b1, 1'b1, "R7 xclr", "R7 chain", "R9 nolock");
   endtask

   // R3, R5: fast clock first, base clock later
   task automatic t_fast_first();
      rst_n = 1'b0;
      run1  = 1'b0;
      #120;
      rst_n = 1'b1;
      repeat (10) begin
         #13;
         chk(ph_x, 1'b0, "R3 xclr fast only");
         chk(ph_c, 1'b0, "R5 chain fast only");
         chk(ph_n, 1'b0, "R5 nolock fast only");
      end
      run1 = 1'b1;
      repeat (3) chk_period(1'b1, 1'b1, 1'b1, "R3 xclr", "R5 chain", "R5 nolock");
   endtask

   // R5: base clock alone never starts the chain
   task automatic t_base_only();
      rst_n  = 1'b0;
      lock_a = 1'b0;
      run2   = 1'b0;
      #120;
      rst_n = 1'b1;
      repeat (10) begin
         #13;
         chk(ph_x, 1'b0, "R7 xclr lock low");
         chk(ph_c, 1'b0, "R5 chain base only");
         chk(ph_n, 1'b0, "R5 nolock base only");
      end
      run2 = 1'b1;
      @(posedge clk_1x);
      #5 lock_a = 1'b1;
      @(posedge clk_1x);
      repeat (3) chk_period(1'b1, 1'b1, 1'b1, "R2 xclr", "R5 R4 chain", "R5 nolock");
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion at %0t", $time);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

   initial begin
      rst_n  = 1'b0;
      lock_a = 1'b1;
      lock_b = 1'b1;
      t_reset_and_start();
      t_async_reset();
      t_lock_loss();
      t_fast_first();
      t_base_only();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule